// File: doc/BRIEF.md
# Dual 16-bit Multiply-Accumulate Unit

This block is a two-stage pipelined datapath for packed halfword arithmetic. Each accepted transfer carries two 32-bit operands and a 32-bit signed accumulator. The block multiplies the lower signed halfwords of the two operands together and the upper signed halfwords together. It adds both products to the accumulator at full precision and returns the low 32 bits of that exact total.

A sticky overflow flag reports whether any returned result failed to represent its exact total. The test is made once, on the complete three-term sum. Two large products can overflow 32 bits between themselves while the accumulator brings the total back into range, and that case leaves the flag alone. A ready/valid pair on each side carries operands in and results out, and a dedicated clear input drops the flag.

Top module: `dmac_top`

## Requirements
- R1: Bits 15:0 of `in_a` and bits 15:0 of `in_b` are multiplied as two's-complement 16-bit numbers, so 0xFFFF counts as -1.
- R2: Bits 31:16 of `in_a` and bits 31:16 of `in_b` are multiplied as two's-complement 16-bit numbers.
- R3: `out_result` equals the low 32 bits of the exact sum of both products and `in_acc`, with `in_acc` read as a signed 32-bit value.
- R4: `q_flag` rises only in the cycle a result enters the output register, and only if sign-extending that 32-bit result gives a value different from the exact sum. This covers both positive overflow and negative overflow.
- R5: If only the sum of the two products overflows 32 bits, `q_flag` is not set. With both operands 0x80008000 and accumulator 0xFFFFFFFF the result is 0x7FFFFFFF with the flag clear, and with accumulator 0x80000000 the result is 0x00000000 with the flag clear.
- R6: Once set, `q_flag` stays high through any number of later results that do not overflow.
- R7: `q_clr` high at a clock edge clears `q_flag`, unless an overflowing result enters the output register at that same edge, in which case the flag is high afterwards.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` holds its value. When both stages are occupied, `in_ready` is low. Results leave in the order their operands were accepted.
- R9: With `out_ready` held high, a transfer accepted at clock edge k shows up on `out_result` with `out_valid` high after edge k+1, and back-to-back transfers sustain one result per cycle.
- R10: Driving `rst_n` low empties both stages (`out_valid` low), clears `q_flag`, and leaves `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Operand transfer offered |
| in_ready | output | 1 | Block can take an operand transfer this cycle |
| in_a | input | 32 | First packed operand, two signed halfwords |
| in_b | input | 32 | Second packed operand, two signed halfwords |
| in_acc | input | 32 | Signed accumulator term |
| out_valid | output | 1 | Result register holds an unconsumed result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Low 32 bits of the exact three-term sum |
| q_clr | input | 1 | Clears the sticky overflow flag |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
The case that is hardest to reach from the ports is a clear request that lands on the same edge as an overflowing result entering the output register. The clear has to be raised exactly one cycle after the operand handshake, and that requires knowing the pipeline timing precisely. The bench sets this up from an empty pipeline with the consumer ready, so the load edge is known in advance. A second hard case is a full pipeline held under backpressure. The bench gets there by dropping `out_ready` before issuing two transfers, then releasing it and checking that the results drain in issue order. The vector table also includes operand sets whose product-only sum overflows 32 bits while the full total does not.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  // default geometry: two signed halfword lanes
  localparam int unsigned DMAC_HALF_W = 16;
  localparam int unsigned DMAC_LANES  = 2;

  // width that holds LANES products plus a signed accumulator exactly,
  // with one spare bit for the sign
  function automatic int unsigned dmac_sum_width(int unsigned half_w,
                                                 int unsigned lanes);
    return 2 * half_w + $clog2(lanes + 1) + 1;
  endfunction

endpackage

// File: rtl/dmac_lane_mul.sv
module dmac_lane_mul #(
  parameter  int unsigned HALF_W = 16,
  localparam int unsigned PROD_W = 2 * HALF_W
) (
  input  logic [HALF_W-1:0] op_x,
  input  logic [HALF_W-1:0] op_y,
  output logic [PROD_W-1:0] prod
);

  logic signed [PROD_W-1:0] x_ext;
  logic signed [PROD_W-1:0] y_ext;

  // sign-extend both halfwords to product width before multiplying
  always_comb begin
    x_ext = {{HALF_W{op_x[HALF_W-1]}}, op_x};
    y_ext = {{HALF_W{op_y[HALF_W-1]}}, op_y};
    prod  = x_ext * y_ext;
  end

endmodule

// File: rtl/dmac_mul_stage.sv
module dmac_mul_stage #(
  parameter  int unsigned HALF_W = 16,
  parameter  int unsigned LANES  = 2,
  localparam int unsigned WORD_W = HALF_W * LANES,
  localparam int unsigned PROD_W = 2 * HALF_W,
  localparam int unsigned PVEC_W = PROD_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic [WORD_W-1:0] acc_in,
  output logic [PVEC_W-1:0] prods_q,
  output logic [WORD_W-1:0] acc_q
);

  logic [PVEC_W-1:0] prods_d;
  logic [PVEC_W-1:0] prods_nxt;
  logic [WORD_W-1:0] acc_nxt;

  // one multiplier per halfword lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dmac_lane_mul #(.HALF_W(HALF_W)) u_mul (
      .op_x (op_a[g*HALF_W +: HALF_W]),
      .op_y (op_b[g*HALF_W +: HALF_W]),
      .prod (prods_d[g*PROD_W +: PROD_W])
    );
  end

  // next state: capture on enable, otherwise hold
  always_comb begin
    prods_nxt = prods_q;
    acc_nxt   = acc_q;
    if (load_en) begin
      prods_nxt = prods_d;
      acc_nxt   = acc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prods_q <= '0;
      acc_q   <= '0;
    end else begin
      prods_q <= prods_nxt;
      acc_q   <= acc_nxt;
    end
  end

endmodule

// File: rtl/dmac_sum_stage.sv
module dmac_sum_stage #(
  parameter  int unsigned HALF_W = 16,
  parameter  int unsigned LANES  = 2,
  parameter  int unsigned SUM_W  = 35,
  localparam int unsigned WORD_W = HALF_W * LANES,
  localparam int unsigned PROD_W = 2 * HALF_W,
  localparam int unsigned PVEC_W = PROD_W * LANES,
  localparam int unsigned TOP_W  = SUM_W - WORD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [PVEC_W-1:0] prods,
  input  logic [WORD_W-1:0] acc,
  output logic              ovf_now,
  output logic [WORD_W-1:0] result_q
);

  logic [SUM_W-1:0]  total;
  logic [TOP_W-1:0]  top_bits;
  logic [WORD_W-1:0] result_nxt;

  // exact sum: every term sign-extended to SUM_W before adding
  always_comb begin
    total = {{(SUM_W-WORD_W){acc[WORD_W-1]}}, acc};
    for (int i = 0; i < LANES; i++) begin
      total = total + {{(SUM_W-PROD_W){prods[i*PROD_W+PROD_W-1]}},
                       prods[i*PROD_W +: PROD_W]};
    end
  end

  // the word is exact only if every bit above its sign bit matches it
  always_comb begin
    top_bits = total[SUM_W-1:WORD_W-1];
    ovf_now  = !((&top_bits) || !(|top_bits));
  end

  always_comb begin
    result_nxt = result_q;
    if (load_en) begin
      result_nxt = total[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else begin
      result_q <= result_nxt;
    end
  end

endmodule

// File: rtl/dmac_qflag.sv
module dmac_qflag (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic ovf_in,
  input  logic clr,
  output logic q
);

  logic q_nxt;

  // clear first, then a new overflow sets: a set in the same cycle wins
  always_comb begin
    q_nxt = q & ~clr;
    if (load_en && ovf_in) begin
      q_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter  int unsigned HALF_W = DMAC_HALF_W,
  parameter  int unsigned LANES  = DMAC_LANES,
  localparam int unsigned WORD_W = HALF_W * LANES,
  localparam int unsigned PROD_W = 2 * HALF_W,
  localparam int unsigned PVEC_W = PROD_W * LANES,
  localparam int unsigned SUM_W  = dmac_sum_width(HALF_W, LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic [WORD_W-1:0] in_acc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result,
  input  logic              q_clr,
  output logic              q_flag
);

  logic              s1_valid;
  logic              s1_valid_nxt;
  logic              s2_valid;
  logic              s2_valid_nxt;
  logic              s2_ready;
  logic              in_fire;
  logic              s2_load;
  logic              sum_ovf;
  logic [PVEC_W-1:0] s1_prods;
  logic [WORD_W-1:0] s1_acc;

  // flow control: a stage accepts when empty or when it drains this cycle
  always_comb begin
    s2_ready = !s2_valid || out_ready;
    s2_load  = s1_valid && s2_ready;
    in_ready = !s1_valid || s2_ready;
    in_fire  = in_valid && in_ready;
  end

  always_comb begin
    s1_valid_nxt = s1_valid;
    if (in_fire) begin
      s1_valid_nxt = 1'b1;
    end else if (s2_load) begin
      s1_valid_nxt = 1'b0;
    end

    s2_valid_nxt = s2_valid;
    if (s2_load) begin
      s2_valid_nxt = 1'b1;
    end else if (out_ready) begin
      s2_valid_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
    end else begin
      s1_valid <= s1_valid_nxt;
      s2_valid <= s2_valid_nxt;
    end
  end

  dmac_mul_stage #(.HALF_W(HALF_W), .LANES(LANES)) u_mul_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (in_fire),
    .op_a    (in_a),
    .op_b    (in_b),
    .acc_in  (in_acc),
    .prods_q (s1_prods),
    .acc_q   (s1_acc)
  );

  dmac_sum_stage #(.HALF_W(HALF_W), .LANES(LANES), .SUM_W(SUM_W)) u_sum_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (s2_load),
    .prods    (s1_prods),
    .acc      (s1_acc),
    .ovf_now  (sum_ovf),
    .result_q (out_result)
  );

  dmac_qflag u_qflag (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (s2_load),
    .ovf_in  (sum_ovf),
    .clr     (q_clr),
    .q       (q_flag)
  );

  assign out_valid = s2_valid;

endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_result,
  input logic              q_clr,
  input logic              q_flag,
  input logic              s1_valid,
  input logic              s2_load
);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)); // R8

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && out_valid && !out_ready |-> !in_ready); // R8

  AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    q_flag && !q_clr |=> q_flag); // R6

  AST_Q_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    q_clr && !s2_load |=> !q_flag); // R7

  AST_Q_RISE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !q_flag && !s2_load |=> !q_flag); // R4

endmodule

bind dmac_top dmac_chk #(.WORD_W(WORD_W)) u_dmac_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .q_clr      (q_clr),
  .q_flag     (q_flag),
  .s1_valid   (s1_valid),
  .s2_load    (s2_load)
);

// File: tb/dmac_top_tb_top.sv
module dmac_top_tb_top;

  localparam time CLK_P = 20ns;  // 50 MHz
  localparam int  NVEC  = 10;

  // entry: a, b, acc, expected result, expected flag
  localparam logic [128:0] VEC [NVEC] = '{
    {32'h00030002, 32'h00050004, 32'h00000001, 32'h00000018, 1'b0}, // R1 R2 R3
    {32'h80008000, 32'h80008000, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b0}, // R5
    {32'h80008000, 32'h80008000, 32'h00000000, 32'h80000000, 1'b1}, // R4 positive
    {32'hFFFF0001, 32'h00020003, 32'h0000000A, 32'h0000000B, 1'b0}, // R2 negative high
    {32'h0000FFFF, 32'h00000005, 32'h00000000, 32'hFFFFFFFB, 1'b0}, // R1 negative low
    {32'h80008000, 32'h7FFF7FFF, 32'h80000000, 32'h00010000, 1'b1}, // R4 negative
    {32'h00000000, 32'h00000000, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0}, // R4 edge
    {32'h00000001, 32'h00000001, 32'h7FFFFFFF, 32'h80000000, 1'b1}, // R4 just over
    {32'h80008000, 32'h80008000, 32'h80000000, 32'h00000000, 1'b0}, // R5
    {32'h7FFF7FFF, 32'h7FFF7FFF, 32'h00010000, 32'h7FFF0002, 1'b0}  // R3
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_a;
  logic [31:0] in_b;
  logic [31:0] in_acc;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_result;
  logic        q_clr;
  logic        q_flag;

  int checks;
  int fails;

  dmac_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_a       (in_a),
    .in_b       (in_b),
    .in_acc     (in_acc),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result),
    .q_clr      (q_clr),
    .q_flag     (q_flag)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one transfer from an idle pipeline; returns at the negedge after acceptance
  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_a     = a;
    in_b     = b;
    in_acc   = c;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out();
    for (int i = 0; i < 8; i++) begin
      if (out_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    q_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    q_clr = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks    = 0;
    fails     = 0;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_a      = '0;
    in_b      = '0;
    in_acc    = '0;
    out_ready = 1'b1;
    q_clr     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk("R10 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R10 q_flag after reset", {31'd0, q_flag}, 32'd0);
    chk("R10 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // table walk, flag cleared before each entry
    for (int v = 0; v < NVEC; v++) begin
      pulse_clear();
      send(VEC[v][128:97], VEC[v][96:65], VEC[v][64:33]);
      wait_out();
      chk($sformatf("R3 vector %0d result", v), out_result, VEC[v][32:1]);
      chk($sformatf("R4 R5 vector %0d flag", v), {31'd0, q_flag}, {31'd0, VEC[v][0]});
    end

    // R6 sticky through a non-overflowing result
    pulse_clear();
    send(32'h80008000, 32'h80008000, 32'h00000000);
    wait_out();
    chk("R6 flag set by overflow", {31'd0, q_flag}, 32'd1);
    send(32'h00030002, 32'h00050004, 32'h00000001);
    wait_out();
    chk("R6 clean result", out_result, 32'h00000018);
    chk("R6 flag still set", {31'd0, q_flag}, 32'd1);

    // R7 clear while idle
    pulse_clear();
    chk("R7 flag cleared", {31'd0, q_flag}, 32'd0);

    // R7 clear on the same edge an overflowing result loads: set wins
    send(32'h80008000, 32'h80008000, 32'h00000000);
    q_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    q_clr = 1'b0;
    chk("R7 out_valid at collision", {31'd0, out_valid}, 32'd1);
    chk("R7 set wins over clear", {31'd0, q_flag}, 32'd1);
    pulse_clear();

    // R8 backpressure with both stages full
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1;
    in_a = 32'h00030002; in_b = 32'h00050004; in_acc = 32'h00000001;
    @(posedge clk);
    @(negedge clk);
    in_a = 32'hFFFF0001; in_b = 32'h00020003; in_acc = 32'h0000000A;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 out_valid held", {31'd0, out_valid}, 32'd1);
    chk("R8 first result held", out_result, 32'h00000018);
    chk("R8 in_ready low when full", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8 second result in order", out_result, 32'h0000000B);
    chk("R8 second out_valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R8 drained", {31'd0, out_valid}, 32'd0);

    // R9 back-to-back stream, two-edge latency
    @(negedge clk);
    in_valid = 1'b1;
    in_a = 32'h00030002; in_b = 32'h00050004; in_acc = 32'h00000001;
    @(negedge clk);
    in_a = 32'hFFFF0001; in_b = 32'h00020003; in_acc = 32'h0000000A;
    @(negedge clk);
    chk("R9 first latency", out_result, 32'h00000018);
    chk("R9 first valid", {31'd0, out_valid}, 32'd1);
    in_a = 32'h0000FFFF; in_b = 32'h00000005; in_acc = 32'h00000000;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second result", out_result, 32'h0000000B);
    @(negedge clk);
    chk("R9 third result", out_result, 32'hFFFFFFFB);
    chk("R9 third valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R9 stream ended", {31'd0, out_valid}, 32'd0);

    // R10 reset with a set flag and a busy pipeline
    out_ready = 1'b0;
    send(32'h80008000, 32'h80008000, 32'h00000000);
    send(32'h00030002, 32'h00050004, 32'h00000001);
    @(negedge clk);
    chk("R10 flag set before reset", {31'd0, q_flag}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R10 q_flag in reset", {31'd0, q_flag}, 32'd0);
    chk("R10 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    out_ready = 1'b1;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule